// File: doc/BRIEF.md
# Battery charge control sequencer

This block is the digital controller of a single-cell lithium charger. It reads the charger's comparator flags, a slow timer tick and a current-limit select pin. From them it sequences the charge phases, keeps two safety timers, and drives four outputs: a 2-bit charge-current request to the analog regulation loop, a charge enable, and the pull-down controls of the open-drain power-good and charge-status pins. A control output of 1 means the pin is pulled low. A control output of 0 means the pin is released.

While the supply is below the lockout level, everything is cleared and all outputs are released. Above that level, the block is in sleep while the supply does not clear the battery voltage plus headroom, and active otherwise. While active and enabled with a battery present, a charge cycle runs through these phases:
- precharge, which also serves as the qualification step and lasts at least one cycle;
- fast charge, which covers both constant current and constant voltage; the analog loop moves between the two on its own;
- done, entered when the current falls below the termination level.

A junction over the thermal limit reduces the requested current. Sleep freezes the sequencer, including the timers and the status flag, and normal operation resumes where it stopped. The status pin is pulled only during the first cycle after a fresh start. A cycle restarted by recharge or by leaving test mode does not pull it again.

Top module: `chg_seq`

## Requirements
- R1: While `in_above_uvlo` is 0, all outputs are 0 and the sequencer and timers are cleared. When the input returns with the input above the battery voltage, a new cycle starts with `chg_pull` = 1.
- R2: In sleep (`in_above_uvlo` = 1, `in_above_bat` = 0), `cur_req` = 00, `chg_en` = 0, `pg_pull` = 0 and `chg_pull` = 0.
- R3: Sleep holds the phase, both timer counts and the status flag. On return, the outputs are as before sleep, and the timers continue from their held counts.
- R4: Whenever active, `pg_pull` = 1. A new cycle begins in precharge (`cur_req` = 01) with `chg_en` = 1. `ilim_hi` is the value of `ilim_sel` sampled in the first active cycle, and it is 0 when not active.
- R5: In precharge, `bat_low` = 0 moves the cycle to fast charge (`cur_req` = 10) at the next clock.
- R6: In fast charge, `cur_below_term` = 1 with `tj_hot` = 0 and `test_mode` = 0 moves the cycle to done: `cur_req` = 00, `chg_en` = 0, `chg_pull` = 0.
- R7: While charging, `tj_hot` = 1 makes `cur_req` = 11, and termination is ignored.
- R8: The PRE_TICKS-th tick spent in precharge (default 6) moves the cycle to fault.
- R9: The TOT_TICKS-th tick spent in precharge and fast charge together (default 20) moves the cycle to fault.
- R10: In fault, `chg_en` = 0, `cur_req` = 00 and `chg_pull` = 0, until a new-cycle event occurs.
- R11: In done or fault, `bat_below_rch` = 1 restarts precharge with `chg_pull` left at 0.
- R12: `en` = 0 or `bat_present` = 0 stops charging and clears the cycle. When both are 1 again, a new cycle starts with `chg_pull` = 1.
- R13: While `test_mode` = 1, ticks are not counted and termination is ignored. A falling edge of `test_mode` restarts precharge with the timers cleared and `chg_pull` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_above_uvlo | input | 1 | Input above lockout level |
| in_above_bat | input | 1 | Input above battery voltage plus headroom |
| bat_low | input | 1 | Battery below low-voltage level |
| bat_below_rch | input | 1 | Battery below recharge level |
| cur_below_term | input | 1 | Charge current below termination level |
| tj_hot | input | 1 | Junction above thermal limit |
| bat_present | input | 1 | Battery detected |
| en | input | 1 | Charger enable |
| test_mode | input | 1 | Termination and timer disable mode |
| tick | input | 1 | Safety timer tick, one cycle wide |
| ilim_sel | input | 1 | Input current limit select |
| cur_req | output | 2 | 00 off, 01 precharge, 10 fast, 11 thermally reduced |
| chg_en | output | 1 | Charge enable |
| ilim_hi | output | 1 | High input current limit selected |
| pg_pull | output | 1 | Pull power-good pin low |
| chg_pull | output | 1 | Pull charge-status pin low |

## Verification
The assertions assume that every flag is synchronous to `clk` and already filtered by the comparators, and that `tick` is a single-cycle pulse. They do not guard against flags that chatter within a cycle, and no check compares one tick to the next.

The stimulus changes inputs only on falling clock edges and drives `tick` as a one-cycle pulse followed by a gap. Each comparator flag is held for at least a cycle, so the sequencer and the reference model see the same values at each rising edge.

// File: rtl/chg_seq.sv
module chg_seq #(
  parameter int PRE_TICKS = 6,
  parameter int TOT_TICKS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_above_uvlo,
  input  logic       in_above_bat,
  input  logic       bat_low,
  input  logic       bat_below_rch,
  input  logic       cur_below_term,
  input  logic       tj_hot,
  input  logic       bat_present,
  input  logic       en,
  input  logic       test_mode,
  input  logic       tick,
  input  logic       ilim_sel,
  output logic [1:0] cur_req,
  output logic       chg_en,
  output logic       ilim_hi,
  output logic       pg_pull,
  output logic       chg_pull
);
  localparam int PW = (PRE_TICKS > 1) ? $clog2(PRE_TICKS) : 1;
  localparam int TW = (TOT_TICKS > 1) ? $clog2(TOT_TICKS) : 1;

  typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_FAST, PH_DONE, PH_FAULT} phase_t;

  phase_t        phase;
  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] tot_cnt;
  logic          chg_st, test_q, act_q, ilim_q;

  logic active, run, charging, cnt_tick, pre_exp, tot_exp, term, start;

  assign active   = in_above_uvlo && in_above_bat;
  assign run      = active && en && bat_present;
  assign charging = (phase == PH_PRE) || (phase == PH_FAST);
  assign cnt_tick = tick && !test_mode;
  assign pre_exp  = cnt_tick && (phase == PH_PRE) && (pre_cnt == PW'(PRE_TICKS - 1));
  assign tot_exp  = cnt_tick && (tot_cnt == TW'(TOT_TICKS - 1));
  assign term     = cur_below_term && !tj_hot && !test_mode;
  assign start    = (phase == PH_IDLE) || (test_q && !test_mode) ||
                    (((phase == PH_DONE) || (phase == PH_FAULT)) && bat_below_rch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; pre_cnt <= '0; tot_cnt <= '0; chg_st <= 1'b0; test_q <= 1'b0;
    end else if (!in_above_uvlo) begin
      phase <= PH_IDLE; pre_cnt <= '0; tot_cnt <= '0; chg_st <= 1'b0; test_q <= 1'b0;
    end else if (active) begin
      test_q <= test_mode;
      if (!en || !bat_present) begin
        phase <= PH_IDLE; pre_cnt <= '0; tot_cnt <= '0; chg_st <= 1'b0;
      end else if (start) begin
        phase   <= PH_PRE;
        pre_cnt <= '0;
        tot_cnt <= '0;
        if (phase == PH_IDLE) chg_st <= 1'b1;
      end else if (charging) begin
        if (pre_exp || tot_exp) begin
          phase  <= PH_FAULT;
          chg_st <= 1'b0;
        end else begin
          if (cnt_tick) begin
            tot_cnt <= tot_cnt + 1'b1;
            if (phase == PH_PRE) pre_cnt <= pre_cnt + 1'b1;
          end
          if (phase == PH_PRE && !bat_low) phase <= PH_FAST;
          else if (phase == PH_FAST && term) begin
            phase  <= PH_DONE;
            chg_st <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ilim_q <= 1'b0;
    end else begin
      act_q <= active;
      if (active && !act_q) ilim_q <= ilim_sel;
    end
  end

  assign chg_en   = run && charging;
  assign cur_req  = !chg_en ? 2'b00 : tj_hot ? 2'b11 : (phase == PH_PRE) ? 2'b01 : 2'b10;
  assign pg_pull  = active;
  assign chg_pull = active && chg_st;
  assign ilim_hi  = active && (act_q ? ilim_q : ilim_sel);

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_above_uvlo && !in_above_bat) |=> ($stable(tot_cnt) && $stable(pre_cnt) && $stable(chg_st))); // R3
  AST_TEST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && test_mode && phase != PH_IDLE) |=> ($stable(pre_cnt) && $stable(tot_cnt))); // R13
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FAULT) |-> (!chg_en && !chg_pull && cur_req == 2'b00)); // R10
  AST_RCH_NO_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == PH_DONE && bat_below_rch) |=> (phase == PH_PRE && !chg_pull)); // R11
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt < PW'(PRE_TICKS)) || (PW'(PRE_TICKS) == '0)); // R8
  AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FAST && tot_exp && !start && run) |=> (phase == PH_FAULT)); // R9
  AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_above_uvlo |=> (phase == PH_IDLE && !chg_st)); // R1
endmodule

// File: tb/test_chg_seq.sv
module test_chg_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo = 0, above = 0, bat_low = 0, rch = 0, term = 0, hot = 0;
  logic present = 0, en = 0, tmode = 0, tick = 0, ilim_sel = 0;
  logic [1:0] cur_req;
  logic chg_en, ilim_hi, pg_pull, chg_pull;
  int checks = 0, errors = 0;

  localparam int PRE_T = 6;
  localparam int TOT_T = 20;

  always #5 clk = ~clk;

  chg_seq #(.PRE_TICKS(PRE_T), .TOT_TICKS(TOT_T)) i_chg_seq (
    .clk(clk), .rst_n(rst_n), .in_above_uvlo(uvlo), .in_above_bat(above),
    .bat_low(bat_low), .bat_below_rch(rch), .cur_below_term(term), .tj_hot(hot),
    .bat_present(present), .en(en), .test_mode(tmode), .tick(tick), .ilim_sel(ilim_sel),
    .cur_req(cur_req), .chg_en(chg_en), .ilim_hi(ilim_hi), .pg_pull(pg_pull), .chg_pull(chg_pull));

  // reference model: 0 idle, 1 precharge, 2 fast, 3 done, 4 fault
  int m_ph = 0, m_pre = 0, m_tot = 0;
  bit m_chg = 0, m_tq = 0, m_act = 0, m_ilim = 0;

  always @(posedge clk or negedge rst_n) begin
    bit act, cnt, fire;
    if (!rst_n) begin
      m_ph = 0; m_pre = 0; m_tot = 0; m_chg = 0; m_tq = 0; m_act = 0; m_ilim = 0;
    end else begin
      act = uvlo && above;
      if (!uvlo) begin
        m_ph = 0; m_pre = 0; m_tot = 0; m_chg = 0; m_tq = 0;
      end else if (act) begin
        cnt = tick && !tmode;
        if (!en || !present) begin
          m_ph = 0; m_pre = 0; m_tot = 0; m_chg = 0;
        end else if (m_ph == 0 || (m_tq && !tmode) || (m_ph >= 3 && rch)) begin
          if (m_ph == 0) m_chg = 1;
          m_ph = 1; m_pre = 0; m_tot = 0;
        end else if (m_ph == 1 || m_ph == 2) begin
          fire = cnt && ((m_ph == 1 && m_pre + 1 == PRE_T) || (m_tot + 1 == TOT_T));
          if (fire) begin
            m_ph = 4; m_chg = 0;
          end else begin
            if (cnt) begin
              m_tot++;
              if (m_ph == 1) m_pre++;
            end
            if (m_ph == 1 && !bat_low) m_ph = 2;
            else if (m_ph == 2 && term && !hot && !tmode) begin
              m_ph = 3; m_chg = 0;
            end
          end
        end
        m_tq = tmode;
      end
      if (act && !m_act) m_ilim = ilim_sel;
      m_act = act;
    end
  end

  task automatic report(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit act, run;
    int e_cur;
    string tag;
    #2;
    if (rst_n) begin
      act = uvlo && above;
      run = act && en && present && (m_ph == 1 || m_ph == 2);
      e_cur = !run ? 0 : hot ? 3 : (m_ph == 1) ? 1 : 2;
      if (!uvlo) tag = "R1";
      else if (!act) tag = "R2";
      else if (m_ph == 1) tag = "R4";
      else if (m_ph == 2) tag = "R5";
      else if (m_ph == 3) tag = "R6";
      else if (m_ph == 4) tag = "R10";
      else tag = "R12";
      report(tag, "cur_req", cur_req, e_cur);
      report(tag, "chg_en", chg_en, run);
      report(tag, "pg_pull", pg_pull, act);
      report(tag, "chg_pull", chg_pull, act && m_chg);
      report("R4", "ilim_hi", ilim_hi, act && (m_act ? m_ilim : ilim_sel));
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_o(string tag, int c, int e, int p, int g);
    #1;
    report(tag, "cur_req", cur_req, c);
    report(tag, "chg_en", chg_en, e);
    report(tag, "pg_pull", pg_pull, p);
    report(tag, "chg_pull", chg_pull, g);
  endtask

  task automatic pulse_tick(int n);
    repeat (n) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    expect_o("R1", 0, 0, 0, 0);
    rst_n = 1; uvlo = 1; above = 0; en = 1; present = 1; bat_low = 1; ilim_sel = 1;
    wait_cyc(2);
    expect_o("R2", 0, 0, 0, 0);
    above = 1;
    wait_cyc(2);
    expect_o("R4", 1, 1, 1, 1);
    report("R4", "ilim_hi", ilim_hi, 1);
    pulse_tick(3);
    above = 0;
    wait_cyc(1);
    expect_o("R2", 0, 0, 0, 0);
    pulse_tick(4);
    above = 1;
    wait_cyc(1);
    expect_o("R3", 1, 1, 1, 1);
    pulse_tick(2);
    expect_o("R3", 1, 1, 1, 1);
    pulse_tick(1);
    expect_o("R8", 0, 0, 1, 0);
    wait_cyc(3);
    expect_o("R10", 0, 0, 1, 0);
    rch = 1;
    wait_cyc(1);
    rch = 0;
    expect_o("R11", 1, 1, 1, 0);
    bat_low = 0;
    wait_cyc(1);
    expect_o("R5", 2, 1, 1, 0);
    hot = 1;
    expect_o("R7", 3, 1, 1, 0);
    term = 1;
    wait_cyc(2);
    expect_o("R7", 3, 1, 1, 0);
    hot = 0;
    wait_cyc(1);
    expect_o("R6", 0, 0, 1, 0);
    en = 0; term = 0;
    wait_cyc(1);
    expect_o("R12", 0, 0, 1, 0);
    en = 1;
    wait_cyc(1);
    expect_o("R12", 1, 1, 1, 1);
    wait_cyc(1);
    expect_o("R5", 2, 1, 1, 1);
    pulse_tick(TOT_T - 1);
    expect_o("R9", 2, 1, 1, 1);
    pulse_tick(1);
    expect_o("R9", 0, 0, 1, 0);
    en = 0; tmode = 1;
    wait_cyc(1);
    en = 1; term = 1;
    wait_cyc(2);
    pulse_tick(TOT_T + 5);
    expect_o("R13", 2, 1, 1, 1);
    tmode = 0; term = 0;
    wait_cyc(1);
    expect_o("R13", 1, 1, 1, 1);
    wait_cyc(1);
    term = 1;
    wait_cyc(1);
    expect_o("R6", 0, 0, 1, 0);
    tmode = 1;
    wait_cyc(1);
    tmode = 0;
    wait_cyc(1);
    expect_o("R13", 1, 1, 1, 0);
    wait_cyc(3);
    present = 0;
    wait_cyc(1);
    expect_o("R12", 0, 0, 1, 0);
    present = 1; term = 0;
    wait_cyc(1);
    expect_o("R12", 1, 1, 1, 1);
    wait_cyc(2);
    uvlo = 0; ilim_sel = 0;
    expect_o("R1", 0, 0, 0, 0);
    report("R1", "ilim_hi", ilim_hi, 0);
    wait_cyc(1);
    uvlo = 1; bat_low = 1;
    wait_cyc(1);
    expect_o("R1", 1, 1, 1, 1);
    report("R4", "ilim_hi", ilim_hi, 0);
    wait_cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule